// File: doc/BRIEF.md
# General-Purpose Port with Latch and Pad Control

This block is one 8-bit general-purpose I/O port that sits on a register bus. It holds three per-pin registers:
- an output latch;
- an analog/digital selection;
- a drive-style selection, open-drain or push-pull.

From these registers, from a global weak-pullup disable and from the peripheral overrides that a crossbar supplies, it produces three controls for each pad: an output enable, an output data bit and a weak-pullup enable.

Software reads the port in one of two ways. A plain read returns the live pin levels, after each pin's digital receiver. A read-modify-write read returns the output latch, so that AND, OR, XOR, complement, increment, decrement, test-and-clear and single-bit operations work on what was written and not on what the pins show. The latch can be written as a whole byte or as a single bit chosen by index.

The read path and the pad controls are combinational from registered state and the current inputs. Register writes take effect at the rising clock edge.

Top module: `gpio_port`

## Requirements
- R1: After reset, the latch holds all ones, every pin is digital (analog-select bit = 1) and every pin is open-drain (drive-style bit = 0). As a result, pad_oe = 0, pad_do = 0 and pad_pu = all ones while pullup_off = 0.
- R2: A byte write (wr_en = 1, wr_bit = 0) loads wr_data into the whole latch at the clock edge.
- R3: A bit write (wr_en = 1, wr_bit = 1) sets latch bit wr_idx to wr_data[0] and leaves every other latch bit unchanged.
- R4: When rd_rmw = 0, rd_data returns pin_in for every digital pin, including pins whose periph_sel bit is 1.
- R5: When rd_rmw = 1, rd_data returns the latch, whatever the pin levels are.
- R6: A pin whose analog-select bit is 0 (analog) reads 0 on a plain read.
- R7: An analog pin has pad_oe = 0, pad_do = 0 and pad_pu = 0, whatever its drive-style bit holds.
- R8: A digital open-drain pin (drive-style bit 0) whose drive value is 1 is released (pad_oe = 0). When its drive value is 0, it has pad_oe = 1 and pad_do = 0.
- R9: A digital push-pull pin (drive-style bit 1) has pad_oe = 1 and pad_do equal to its drive value.
- R10: A pin with periph_sel = 1 takes its drive value from periph_out instead of the latch, and R8 and R9 still apply to it.
- R11: When pullup_off = 1, pad_pu is all zeros. When pullup_off = 0, pad_pu = 1 exactly for digital pins that are not driving low (not pad_oe = 1 with pad_do = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Latch write strobe |
| wr_bit | input | 1 | 1 = single-bit write at wr_idx, 0 = byte write |
| wr_idx | input | 3 | Bit index for single-bit writes |
| wr_data | input | 8 | Byte write data; bit 0 is the value for a bit write |
| amode_we | input | 1 | Write strobe for the analog-select register |
| amode_wdata | input | 8 | Analog-select data: 0 = analog, 1 = digital |
| dmode_we | input | 1 | Write strobe for the drive-style register |
| dmode_wdata | input | 8 | Drive-style data: 0 = open-drain, 1 = push-pull |
| pullup_off | input | 1 | Global weak-pullup disable |
| rd_rmw | input | 1 | 1 = read-modify-write read (latch), 0 = plain read (pins) |
| rd_data | output | 8 | Read data |
| pin_in | input | 8 | Pin levels from the pads |
| periph_sel | input | 8 | Crossbar assignment per pin: 1 = peripheral drives |
| periph_out | input | 8 | Peripheral output values |
| pad_oe | output | 8 | Pad output enable |
| pad_do | output | 8 | Pad output data |
| pad_pu | output | 8 | Pad weak-pullup enable |

## Verification
A register write that the bench drives before a rising edge shows up on rd_data and on the pad controls in that same cycle, just after the edge, because only one register stage lies on the path. A change on pin_in, periph_sel, periph_out, pullup_off or rd_rmw shows up with no clock at all. The bench therefore drives inputs at the falling edge. It then waits for the rising edge, updates its model with the writes that were held over that edge, and samples 2 ns later. Changes that involve only combinational inputs are checked at the falling edge where they are driven, after a short settle delay.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Per-pad control bundle produced by one pad cell.
  typedef struct packed {
    logic oe;
    logic dout;
    logic pu;
  } pad_ctrl_t;

  // Reset values of the per-pin registers.
  localparam logic LATCH_RST = 1'b1;  // latch high
  localparam logic AMODE_RST = 1'b1;  // digital
  localparam logic DMODE_RST = 1'b0;  // open-drain

endpackage

// File: rtl/gpio_port_rstsync.sv
module gpio_port_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          amode_we,
  input  logic [W-1:0]  amode_wdata,
  input  logic          dmode_we,
  input  logic [W-1:0]  dmode_wdata,
  output logic [W-1:0]  latch_q,
  output logic [W-1:0]  amode_q,
  output logic [W-1:0]  dmode_q
);

  logic [W-1:0] latch_d;
  logic         latch_ce;
  logic [W-1:0] amode_d;
  logic         amode_ce;
  logic [W-1:0] dmode_d;
  logic         dmode_ce;

  // Next-state for the latch: whole byte, or one bit chosen by index.
  always_comb begin
    latch_d  = latch_q;
    latch_ce = wr_en;
    if (wr_bit) begin
      for (int i = 0; i < W; i++) begin
        if (wr_idx == IW'(i)) begin
          latch_d[i] = wr_data[0];
        end
      end
    end else begin
      latch_d = wr_data;
    end
  end

  always_comb begin
    amode_ce = amode_we;
    amode_d  = amode_wdata;
    dmode_ce = dmode_we;
    dmode_d  = dmode_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= {W{LATCH_RST}};
    end else if (latch_ce) begin
      latch_q <= latch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amode_q <= {W{AMODE_RST}};
    end else if (amode_ce) begin
      amode_q <= amode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmode_q <= {W{DMODE_RST}};
    end else if (dmode_ce) begin
      dmode_q <= dmode_d;
    end
  end

endmodule

// File: rtl/gpio_port_padcell.sv
module gpio_port_padcell
  import gpio_port_pkg::*;
(
  input  logic      latch_bit,
  input  logic      digital,
  input  logic      push_pull,
  input  logic      psel,
  input  logic      pout,
  input  logic      pu_dis,
  input  logic      pin,
  output pad_ctrl_t ctrl,
  output logic      rx
);

  logic drv_val;
  logic drives_low;

  always_comb begin
    // Source of the drive value: peripheral when assigned, else latch.
    drv_val = psel ? pout : latch_bit;

    ctrl.oe   = 1'b0;
    ctrl.dout = 1'b0;
    if (digital) begin
      if (push_pull) begin
        ctrl.oe   = 1'b1;
        ctrl.dout = drv_val;
      end else begin
        ctrl.oe   = ~drv_val;
        ctrl.dout = 1'b0;
      end
    end

    drives_low = ctrl.oe & ~ctrl.dout;
    ctrl.pu    = digital & ~pu_dis & ~drives_low;

    // Digital receiver is off for analog pins.
    rx = digital & pin;
  end

endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux #(
  parameter int W = 8
) (
  input  logic         rd_rmw,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] rx,
  output logic [W-1:0] rd_data
);

  always_comb begin
    rd_data = rd_rmw ? latch_q : rx;
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             amode_we,
  input  logic [WIDTH-1:0] amode_wdata,
  input  logic             dmode_we,
  input  logic [WIDTH-1:0] dmode_wdata,
  input  logic             pullup_off,
  input  logic             rd_rmw,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] periph_sel,
  input  logic [WIDTH-1:0] periph_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_do,
  output logic [WIDTH-1:0] pad_pu
);

  logic             rst_sync_n;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] amode_q;
  logic [WIDTH-1:0] dmode_q;
  logic [WIDTH-1:0] rx;
  pad_ctrl_t        ctrl [WIDTH];

  gpio_port_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_port_regs #(.W(WIDTH), .IW(IDX_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_en),
    .wr_bit      (wr_bit),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .amode_we    (amode_we),
    .amode_wdata (amode_wdata),
    .dmode_we    (dmode_we),
    .dmode_wdata (dmode_wdata),
    .latch_q     (latch_q),
    .amode_q     (amode_q),
    .dmode_q     (dmode_q)
  );

  for (genvar g = 0; g < WIDTH; g++) begin : g_pad
    gpio_port_padcell u_cell (
      .latch_bit (latch_q[g]),
      .digital   (amode_q[g]),
      .push_pull (dmode_q[g]),
      .psel      (periph_sel[g]),
      .pout      (periph_out[g]),
      .pu_dis    (pullup_off),
      .pin       (pin_in[g]),
      .ctrl      (ctrl[g]),
      .rx        (rx[g])
    );
    assign pad_oe[g] = ctrl[g].oe;
    assign pad_do[g] = ctrl[g].dout;
    assign pad_pu[g] = ctrl[g].pu;
  end

  gpio_port_rdmux #(.W(WIDTH)) u_rd (
    .rd_rmw  (rd_rmw),
    .latch_q (latch_q),
    .rx      (rx),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_bit,
  input logic [IW-1:0] wr_idx,
  input logic [W-1:0]  wr_data,
  input logic          pullup_off,
  input logic          rd_rmw,
  input logic [W-1:0]  rd_data,
  input logic [W-1:0]  latch_q,
  input logic [W-1:0]  amode_q,
  input logic [W-1:0]  dmode_q,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_do,
  input logic [W-1:0]  pad_pu
);

  p_byte_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_bit) |=> (latch_q == $past(wr_data)));

  p_bit_write_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bit) |=>
      (((latch_q ^ $past(latch_q)) & ~(W'(1) << $past(wr_idx))) == '0));

  p_rmw_reads_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rmw |-> (rd_data == latch_q));

  p_analog_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rmw |-> ((rd_data & ~amode_q) == '0));

  p_analog_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_do | pad_pu) & ~amode_q) == '0);

  p_od_never_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_do & ~dmode_q) == '0);

  p_pp_always_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((dmode_q & amode_q) & ~pad_oe) == '0);

  p_pullup_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_off |-> (pad_pu == '0));

  p_no_pullup_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe & ~pad_do) == '0);

endmodule

bind gpio_port gpio_port_chk #(.W(WIDTH), .IW(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_bit     (wr_bit),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .pullup_off (pullup_off),
  .rd_rmw     (rd_rmw),
  .rd_data    (rd_data),
  .latch_q    (latch_q),
  .amode_q    (amode_q),
  .dmode_q    (dmode_q),
  .pad_oe     (pad_oe),
  .pad_do     (pad_do),
  .pad_pu     (pad_pu)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;

  localparam int W  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_bit;
  logic [IW-1:0] wr_idx;
  logic [W-1:0]  wr_data;
  logic          amode_we, dmode_we;
  logic [W-1:0]  amode_wdata, dmode_wdata;
  logic          pullup_off, rd_rmw;
  logic [W-1:0]  rd_data, pin_in, periph_sel, periph_out;
  logic [W-1:0]  pad_oe, pad_do, pad_pu;

  int n_tests = 0;
  int n_fail  = 0;

  logic [W-1:0] m_latch, m_amode, m_dmode;

  always #5 clk = ~clk;

  gpio_port #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .wr_idx(wr_idx),
    .wr_data(wr_data), .amode_we(amode_we), .amode_wdata(amode_wdata),
    .dmode_we(dmode_we), .dmode_wdata(dmode_wdata), .pullup_off(pullup_off),
    .rd_rmw(rd_rmw), .rd_data(rd_data), .pin_in(pin_in), .periph_sel(periph_sel),
    .periph_out(periph_out), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
  );

  // Expected-value functions, written bit by bit from the requirements.
  function automatic logic [W-1:0] f_rd();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = rd_rmw ? m_latch[i] : (m_amode[i] ? pin_in[i] : 1'b0);
    return r;
  endfunction

  function automatic logic f_val(int i);
    return periph_sel[i] ? periph_out[i] : m_latch[i];
  endfunction

  function automatic logic [W-1:0] f_oe();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (!m_amode[i])     r[i] = 1'b0;
      else if (m_dmode[i]) r[i] = 1'b1;
      else                 r[i] = (f_val(i) == 1'b0);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] f_do();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = m_amode[i] && m_dmode[i] && f_val(i);
    return r;
  endfunction

  function automatic logic [W-1:0] f_pu();
    logic [W-1:0] r;
    logic [W-1:0] oe, dv;
    oe = f_oe();
    dv = f_do();
    for (int i = 0; i < W; i++)
      r[i] = !pullup_off && m_amode[i] && !(oe[i] && !dv[i]);
    return r;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] got, input logic [W-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_now(input string tag);
    #1;
    chk(tag, "rd_data", rd_data, f_rd());
    chk(tag, "pad_oe",  pad_oe,  f_oe());
    chk(tag, "pad_do",  pad_do,  f_do());
    chk(tag, "pad_pu",  pad_pu,  f_pu());
  endtask

  // Inputs already driven at a falling edge; clock them in, update model, check.
  task automatic apply(input string tag);
    @(posedge clk);
    if (wr_en) begin
      if (wr_bit) m_latch[wr_idx] = wr_data[0];
      else        m_latch = wr_data;
    end
    if (amode_we) m_amode = amode_wdata;
    if (dmode_we) m_dmode = dmode_wdata;
    #2;
    chk(tag, "rd_data", rd_data, f_rd());
    chk(tag, "pad_oe",  pad_oe,  f_oe());
    chk(tag, "pad_do",  pad_do,  f_do());
    chk(tag, "pad_pu",  pad_pu,  f_pu());
    @(negedge clk);
    wr_en = 0; amode_we = 0; dmode_we = 0;
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h0C0FFEE1));
    rst_n = 0; wr_en = 0; wr_bit = 0; wr_idx = '0; wr_data = '0;
    amode_we = 0; amode_wdata = '0; dmode_we = 0; dmode_wdata = '0;
    pullup_off = 0; rd_rmw = 1; pin_in = 8'h5A; periph_sel = '0; periph_out = '0;
    m_latch = '1; m_amode = '1; m_dmode = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset values visible on the pads and on a latch read.
    check_now("R1 reset");

    // R2: byte write.
    wr_en = 1; wr_bit = 0; wr_data = 8'hA5;
    apply("R2 byte write");

    // R3: bit writes, neighbours untouched.
    wr_en = 1; wr_bit = 1; wr_idx = 3'd1; wr_data = 8'hFF;
    apply("R3 bit set");
    wr_en = 1; wr_bit = 1; wr_idx = 3'd7; wr_data = 8'hFE;
    apply("R3 bit clear");

    // R6 R7: upper nibble analog, all push-pull.
    amode_we = 1; amode_wdata = 8'h0F; dmode_we = 1; dmode_wdata = 8'hFF;
    rd_rmw = 0; pin_in = 8'hFF;
    apply("R6 R7 analog");

    // R8: open-drain, digital.
    amode_we = 1; amode_wdata = 8'hFF; dmode_we = 1; dmode_wdata = 8'h00;
    wr_en = 1; wr_bit = 0; wr_data = 8'h3C;
    apply("R8 open-drain");

    // R9: push-pull.
    dmode_we = 1; dmode_wdata = 8'hFF;
    apply("R9 push-pull");

    // R10: peripheral overrides with mixed drive styles.
    @(negedge clk);
    dmode_we = 1; dmode_wdata = 8'hCC;
    apply("R10 setup");
    periph_sel = 8'hF0; periph_out = 8'h5A;
    check_now("R10 peripheral");

    // R4: plain read returns pins, including crossbar-assigned pins.
    rd_rmw = 0; pin_in = 8'hC3;
    check_now("R4 pin read");

    // R5: latch read ignores pins.
    rd_rmw = 1; pin_in = 8'h00;
    check_now("R5 latch read");

    // R11: global pullup disable, then re-enable.
    pullup_off = 1;
    check_now("R11 pullups off");
    pullup_off = 0;
    check_now("R11 pullups on");

    // Random mix.
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      wr_en       = ($urandom_range(0, 2) == 0);
      wr_bit      = $urandom_range(0, 1);
      wr_idx      = IW'($urandom_range(0, W - 1));
      wr_data     = W'($urandom);
      amode_we    = ($urandom_range(0, 5) == 0);
      amode_wdata = W'($urandom);
      dmode_we    = ($urandom_range(0, 4) == 0);
      dmode_wdata = W'($urandom);
      pullup_off  = ($urandom_range(0, 5) == 0);
      rd_rmw      = $urandom_range(0, 1);
      pin_in      = W'($urandom);
      periph_sel  = W'($urandom);
      periph_out  = W'($urandom);
      apply("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule